// File: doc/BRIEF.md
# Configurable Product-Term Macrocell

A single programmable logic cell that turns a handful of already-formed product terms into one output bit. Every local term carries a small role code. That code decides whether the term joins the OR sum, drives the XOR inverter, clocks the register, gates the clock, sets or clears the register asynchronously, or supplies the second control input of a JK or SR flip-flop. The AND array that forms the terms and the routing that feeds them sit outside this block.

The storage element can load, toggle, act as JK or act as SR, or it can be bypassed so that the XOR result drives the output directly. It can be clocked in three ways: by a global clock chosen from two pins with optional inversion, by that global clock qualified by an enable term, or by a clock built from the terms themselves. A dedicated active-low global clear reaches the register only when the cell is set to honour it.

Top module: `pterm_macrocell`

## Requirements
- R1: Each term i has a 3-bit role code at `pt_role[3i+2:3i]` with the codes 0 sum, 1 XOR operand, 2 array clock, 3 clock enable, 4 preset, 5 clear, 6 second control and 7 unused. The sum is the OR of all high terms whose code is 0.
- R2: When `ff_kind` is 4 to 7, the output is the XOR result, taken combinationally in the same cycle as the term change.
- R3: The XOR result is the sum XOR `xor_pol` XOR the OR of all high terms with code 1.
- R4: `ff_kind` 0 loads the XOR result on the effective clock edge. `ff_kind` 1 inverts the stored bit on that edge when the XOR result is 1.
- R5: For `ff_kind` 2 (JK) and 3 (SR), the first control input is the XOR result and the second is the OR of the code-6 terms. In JK, both high toggles the bit. In SR, both high keeps the bit.
- R6: When `use_gclr` is 1, a low `gclr_n` forces the stored bit to 0 at once, with no clock needed.
- R7: With `clk_mode` 1, the register captures on the global edge only while some code-3 term is high. Otherwise it keeps its value.
- R8: With `clk_mode` 2, the register captures on each rising edge of the OR of the code-2 terms, and the global clocks are ignored.
- R9: With `clk_mode` 0 or 3, the register captures on the rising edge of `clk_b` when `gsel` is 1 and of `clk_a` when `gsel` is 0, inverted when `ginv` is 1.
- R10: A high code-4 term sets the stored bit to 1 at once.
- R11: A high code-5 term clears the stored bit to 0 at once. When a clear term and a preset term are both high, the clear term wins.
- R12: When `use_gclr` is 0, `gclr_n` has no effect on the stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | First global clock pin |
| clk_b | input | 1 | Second global clock pin |
| gclr_n | input | 1 | Dedicated global clear, active low |
| pt | input | NPT | Local product terms |
| pt_role | input | 3*NPT | Role code of each term |
| clk_mode | input | 2 | 0/3 global, 1 global with enable, 2 array clock |
| gsel | input | 1 | Global clock pin select |
| ginv | input | 1 | Global clock inversion |
| ff_kind | input | 3 | 0 D, 1 T, 2 JK, 3 SR, 4-7 bypass |
| use_gclr | input | 1 | Lets the global clear reach the register |
| xor_pol | input | 1 | Fixed output inversion |
| cell_out | output | 1 | Cell output |

## Verification
The bypass path, preset, clear and global clear act within the same cycle in which their inputs change. Registered results appear only after the next effective edge. For the main clock that edge comes one period later. For the inverted second pin it comes 2 ns after the stimulus, and for the array clock it is the moment the clock term itself rises. The bench drives inputs 2 ns after each rise of `clk_a` and samples 8 ns after it. Every such sample falls after whichever edge the active mode selects, so each sample sees a settled result. The behavioural model advances on that same selected edge. Clock-select changes and data changes are never applied together, and the array-clock term is always raised on its own.

// File: rtl/pterm_macrocell.sv
module pterm_macrocell #(
  parameter int NPT = 5,
  localparam int RW = 3
) (
  input  logic              clk_a,
  input  logic              clk_b,
  input  logic              gclr_n,
  input  logic [NPT-1:0]    pt,
  input  logic [NPT*RW-1:0] pt_role,
  input  logic [1:0]        clk_mode,
  input  logic              gsel,
  input  logic              ginv,
  input  logic [2:0]        ff_kind,
  input  logic              use_gclr,
  input  logic              xor_pol,
  output logic              cell_out
);
  localparam int NROLE  = 7;
  localparam int K_SUM  = 0;
  localparam int K_XOR  = 1;
  localparam int K_ACLK = 2;
  localparam int K_CEN  = 3;
  localparam int K_PRE  = 4;
  localparam int K_CLR  = 5;
  localparam int K_AUX  = 6;

  logic [NROLE-1:0] grp;
  logic d_in, aux, gclk, cell_clk, en, clr_any, pre_any, nxt, q_r;

  always_comb begin
    grp = '0;
    for (int i = 0; i < NPT; i++)
      for (int r = 0; r < NROLE; r++)
        if (pt[i] && pt_role[i*RW +: RW] == RW'(r)) grp[r] = 1'b1;
  end

  assign d_in     = grp[K_SUM] ^ grp[K_XOR] ^ xor_pol;
  assign aux      = grp[K_AUX];
  assign gclk     = (gsel ? clk_b : clk_a) ^ ginv;
  assign cell_clk = (clk_mode == 2'd2) ? grp[K_ACLK] : gclk;
  assign en       = (clk_mode == 2'd1) ? grp[K_CEN] : 1'b1;
  assign clr_any  = grp[K_CLR] | (use_gclr & ~gclr_n);
  assign pre_any  = grp[K_PRE];

  always_comb begin
    case (ff_kind)
      3'd0:    nxt = d_in;
      3'd1:    nxt = q_r ^ d_in;
      3'd2:    nxt = (d_in & ~q_r) | (~aux & q_r);
      3'd3:    nxt = (d_in ^ aux) ? d_in : q_r;
      default: nxt = q_r;
    endcase
  end

  always_ff @(posedge cell_clk or posedge clr_any or posedge pre_any) begin
    if (clr_any)      q_r <= 1'b0;
    else if (pre_any) q_r <= 1'b1;
    else if (en)      q_r <= nxt;
  end

  assign cell_out = ff_kind[2] ? d_in : q_r;

  AST_CLR_HOLDS: assert property (@(posedge cell_clk) disable iff (use_gclr && !gclr_n)
    clr_any |-> !q_r); // R11
  AST_D_LOADS: assert property (@(posedge cell_clk) disable iff (clr_any || pre_any)
    (ff_kind == 3'd0 && en) |=> (q_r == $past(d_in))); // R4
  AST_T_FLIPS: assert property (@(posedge cell_clk) disable iff (clr_any || pre_any)
    (ff_kind == 3'd1 && en && d_in) |=> (q_r != $past(q_r))); // R4
  AST_SR_KEEPS: assert property (@(posedge cell_clk) disable iff (clr_any || pre_any)
    (ff_kind == 3'd3 && en && d_in && aux) |=> $stable(q_r)); // R5
  AST_NO_EN_HOLD: assert property (@(posedge cell_clk) disable iff (clr_any || pre_any)
    (clk_mode == 2'd1 && !en) |=> $stable(q_r)); // R7
endmodule

// File: tb/sim_pterm_macrocell.sv
module sim_pterm_macrocell;
  localparam int PERIOD = 10;

  logic clk_a = 1'b0, clk_b = 1'b0, gclr_n = 1'b0;
  logic [4:0] pt = '0;
  logic [2:0] role [5];
  logic [14:0] pt_role;
  logic [1:0] clk_mode = 2'd0;
  logic gsel = 1'b0, ginv = 1'b0, use_gclr = 1'b1, xor_pol = 1'b0;
  logic [2:0] ff_kind = 3'd0;
  logic cell_out;

  int checks = 0, errors = 0;
  string cur_req = "R6";
  bit live = 1'b0;
  logic [7:0] lfsr = 8'h5a;

  pterm_macrocell u0 (.clk_a(clk_a), .clk_b(clk_b), .gclr_n(gclr_n), .pt(pt), .pt_role(pt_role),
    .clk_mode(clk_mode), .gsel(gsel), .ginv(ginv), .ff_kind(ff_kind), .use_gclr(use_gclr),
    .xor_pol(xor_pol), .cell_out(cell_out));

  always #(PERIOD/2) clk_a = ~clk_a;
  initial begin
    #4;
    forever begin clk_b = 1'b1; #(PERIOD/2); clk_b = 1'b0; #(PERIOD/2); end
  end

  always_comb for (int i = 0; i < 5; i++) pt_role[i*3 +: 3] = role[i];

  // behavioural reference
  logic [7:0] hit;
  logic m_d, m_clk, m_en, m_clr, m_pre, m_nq, mq, m_out;
  always_comb begin
    hit = '0;
    for (int i = 0; i < 5; i++) if (pt[i]) hit[role[i]] = 1'b1;
    m_d   = hit[0] ^ hit[1] ^ xor_pol;
    if (clk_mode == 2'd2) m_clk = hit[2];
    else if (gsel)        m_clk = ginv ? ~clk_b : clk_b;
    else                  m_clk = ginv ? ~clk_a : clk_a;
    m_en  = (clk_mode == 2'd1) ? hit[3] : 1'b1;
    m_pre = hit[4];
    m_clr = hit[5] || (use_gclr && !gclr_n);
    if (ff_kind == 3'd0) m_nq = m_d;
    else if (ff_kind == 3'd1) m_nq = m_d ? !mq : mq;
    else if (ff_kind == 3'd2) begin
      if (m_d && hit[6]) m_nq = !mq;
      else if (m_d) m_nq = 1'b1;
      else if (hit[6]) m_nq = 1'b0;
      else m_nq = mq;
    end else if (ff_kind == 3'd3) begin
      if (m_d && !hit[6]) m_nq = 1'b1;
      else if (!m_d && hit[6]) m_nq = 1'b0;
      else m_nq = mq;
    end else m_nq = mq;
    m_out = (ff_kind >= 3'd4) ? m_d : mq;
  end

  always @(posedge m_clk or posedge m_clr or posedge m_pre) begin
    if (m_clr) mq <= 1'b0;
    else if (m_pre) mq <= 1'b1;
    else if (m_en) mq <= m_nq;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always begin
    @(posedge clk_a); #8;
    if (live) chk(cur_req, cell_out, m_out);
  end

  task automatic step(input logic [4:0] v);
    @(posedge clk_a); #2; pt = v;
  endtask

  task automatic dchk(input string req, input logic exp);
    #6; chk(req, cell_out, exp);
  endtask

  task automatic cfg_clk(input logic [1:0] m, input logic s, input logic i);
    step(5'd0);
    @(posedge clk_a); #2; clk_mode = m; gsel = s; ginv = i;
  endtask

  task automatic rnd(input int n, input logic [4:0] mask);
    for (int k = 0; k < n; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[4:0] & mask);
    end
  endtask

  task automatic roles(input logic [2:0] r0, input logic [2:0] r1, input logic [2:0] r2,
                       input logic [2:0] r3, input logic [2:0] r4);
    step(5'd0);
    role[0] = r0; role[1] = r1; role[2] = r2; role[3] = r3; role[4] = r4;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) role[i] = 3'd7;
    repeat (2) @(posedge clk_a);
    live = 1'b1;
    #8; chk("R6", cell_out, 1'b0);
    step(5'd0); gclr_n = 1'b1;

    cur_req = "R1"; ff_kind = 3'd4;
    roles(3'd0, 3'd0, 3'd7, 3'd7, 3'd7);
    rnd(16, 5'h1f);
    step(5'b00010); dchk("R1", 1'b1);
    step(5'b00000); dchk("R1", 1'b0);
    cur_req = "R2";
    step(5'b00001); dchk("R2", 1'b1);

    cur_req = "R3";
    roles(3'd0, 3'd0, 3'd1, 3'd7, 3'd7); xor_pol = 1'b1;
    step(5'd0); dchk("R3", 1'b1);
    step(5'b00100); dchk("R3", 1'b0);
    step(5'b00101); dchk("R3", 1'b1);
    rnd(16, 5'h1f);

    cur_req = "R4"; xor_pol = 1'b0;
    roles(3'd0, 3'd0, 3'd7, 3'd7, 3'd7); ff_kind = 3'd0;
    step(5'd1); step(5'd1); dchk("R4", 1'b1);
    rnd(16, 5'h1f);
    roles(3'd0, 3'd0, 3'd7, 3'd7, 3'd7); ff_kind = 3'd1;
    rnd(16, 5'h1f);

    cur_req = "R5";
    roles(3'd0, 3'd0, 3'd6, 3'd7, 3'd7); ff_kind = 3'd2;
    rnd(16, 5'h1f);
    step(5'd1); step(5'd1); dchk("R5", 1'b1);
    step(5'd5); step(5'd5); dchk("R5", 1'b0);
    step(5'd5); dchk("R5", 1'b1);
    roles(3'd0, 3'd0, 3'd6, 3'd7, 3'd7); ff_kind = 3'd3;
    rnd(16, 5'h1f);
    step(5'd1); step(5'd5); dchk("R5", 1'b1);
    step(5'd5); dchk("R5", 1'b1);
    step(5'd4); step(5'd4); dchk("R5", 1'b0);
    step(5'd5); step(5'd5); dchk("R5", 1'b0);

    cur_req = "R7";
    roles(3'd0, 3'd7, 3'd7, 3'd3, 3'd7); ff_kind = 3'd0;
    cfg_clk(2'd1, 1'b0, 1'b0);
    step(5'd8); step(5'd1); step(5'd1); dchk("R7", 1'b0);
    step(5'd9); step(5'd9); dchk("R7", 1'b1);
    rnd(16, 5'h1f);

    cur_req = "R8";
    roles(3'd0, 3'd0, 3'd7, 3'd2, 3'd7);
    cfg_clk(2'd2, 1'b0, 1'b0);
    step(5'd1); step(5'd9); dchk("R8", 1'b1);
    step(5'd0); dchk("R8", 1'b1);
    step(5'd8); dchk("R8", 1'b0);
    for (int k = 0; k < 12; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[4:0] & 5'b10111);
      step((lfsr[4:0] & 5'b10111) | 5'b01000);
    end

    cur_req = "R9";
    roles(3'd0, 3'd7, 3'd7, 3'd7, 3'd7);
    cfg_clk(2'd0, 1'b1, 1'b1);
    step(5'd1); dchk("R9", 1'b1);
    step(5'd0); dchk("R9", 1'b0);
    rnd(12, 5'h1f);
    cfg_clk(2'd0, 1'b0, 1'b1);
    step(5'd1); dchk("R9", 1'b1);
    step(5'd0); dchk("R9", 1'b0);
    rnd(12, 5'h1f);
    cfg_clk(2'd3, 1'b0, 1'b0);
    step(5'd1); step(5'd1); dchk("R9", 1'b1);

    cur_req = "R10";
    roles(3'd0, 3'd7, 3'd7, 3'd4, 3'd5);
    cfg_clk(2'd0, 1'b0, 1'b0);
    step(5'd0); dchk("R10", 1'b0);
    step(5'd8); dchk("R10", 1'b1);
    cur_req = "R11";
    step(5'd24); dchk("R11", 1'b0);
    step(5'd0); dchk("R11", 1'b0);
    step(5'd17); dchk("R11", 1'b0);
    cur_req = "R10";
    step(5'd8); dchk("R10", 1'b1);

    cur_req = "R12";
    roles(3'd0, 3'd7, 3'd7, 3'd7, 3'd7); use_gclr = 1'b0;
    step(5'd1); step(5'd1); dchk("R12", 1'b1);
    step(5'd1); gclr_n = 1'b0; dchk("R12", 1'b1);
    step(5'd1); dchk("R12", 1'b1);
    cur_req = "R6";
    step(5'd1); use_gclr = 1'b1; dchk("R6", 1'b0);
    step(5'd1); dchk("R6", 1'b0);
    step(5'd1); gclr_n = 1'b1;
    step(5'd1); dchk("R6", 1'b1);

    live = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 5000);
    errors++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule